// File: doc/BRIEF.md
# Exception Acceptance and Priority Unit

This unit sits next to the commit stage of a simple in-order pipeline. In every cycle it looks at three sources of pending events: a reset-class request, a general exception request raised by the committing instruction, and an interrupt request. It selects at most one of them. For an accepted event it decides whether the committing instruction is cancelled or allowed to finish. It computes the address that execution returns to and places it in a saved-PC register. It also copies the live status word into a saved-status register.

Each general exception is tagged as either re-execute or complete. Re-execute cancels the instruction and saves its own address. Complete lets the instruction finish and saves the address of the instruction that follows it. The unit records internally whether the previous committed instruction was a taken delayed branch, so it knows when the current commit is a delay slot. Delay-slot context changes the saved address. A complete-type exception raised on a taken delayed branch is held back until the branch's delay slot commits, and the branch target is then saved. The live status word holds a block bit. While the block bit is set, interrupts wait, and a general exception is escalated to a reset-class event.

Top module: `exc_accept_unit`

## Requirements
- R1: A reset request is always accepted one clock later with `vec_o`=1 (reset class) and `evt_code_o`=0x00, whatever the block bit or the other requests are. A general exception wins over an interrupt in the same cycle.
- R2: An interrupt is accepted only in a cycle with `commit_valid`=1, no reset request, no general request (new or held back), the block bit (status bit 28) clear, and a commit that is not a taken delayed branch. Otherwise it is not accepted in that cycle.
- R3: A re-execute general exception (`gexc_reexec`=1) outside a delay slot sets `flush_o`=1 and saves `cur_pc` into `spc_o`.
- R4: A complete-type general exception outside any delayed-branch context sets `flush_o`=0 and saves `cur_pc`+2 into `spc_o`.
- R5: A re-execute exception in a delay slot saves the address of the delayed branch that owns the slot.
- R6: A complete-type exception raised on a taken delayed branch is accepted when the next valid commit (its slot) occurs, and saves the branch target. Complete-type exceptions and interrupts raised in a delay slot also save the branch target.
- R7: A commit counts as a delay slot only after an unconditional delayed branch (`cur_br_kind`=1) or a conditional one (`cur_br_kind`=2) with `cur_br_taken`=1. After a not-taken conditional branch, the next commit is handled normally.
- R8: On a general or interrupt acceptance, `ssr_o` takes the status word from before the event, and the block bit is set in `sr_o` on the same edge.
- R9: A general exception arriving while the block bit is 1 is escalated: `vec_o`=1, `evt_code_o`=0x01, `flush_o`=1, and `spc_o`/`ssr_o` are unchanged.
- R10: `accept_o` is high for one cycle per accepted event and only one event is accepted per cycle. `vec_o` is 0 when nothing is accepted, 2 for general and 3 for interrupt, and `evt_code_o` carries the request's code.
- R11: A reset-class acceptance leaves `spc_o` and `ssr_o` unchanged and loads the status word with only the block bit set (0x1000_0000), which is also its value after `rst`.
- R12: `sr_we` writes `sr_wdata` into the status word when no event is accepted in that cycle. An acceptance overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | Reset-class event request |
| commit_valid | input | 1 | An instruction commits this cycle |
| cur_pc | input | 32 | Address of the committing instruction |
| cur_br_kind | input | 2 | 0 none, 1 unconditional delayed branch, 2 conditional delayed branch |
| cur_br_taken | input | 1 | Condition of a conditional delayed branch is true |
| cur_br_target | input | 32 | Target of the committing delayed branch |
| gexc_req | input | 1 | General exception raised by the committing instruction |
| gexc_reexec | input | 1 | 1 re-execute type, 0 complete type |
| gexc_code | input | 8 | Event code of the general exception |
| irq_req | input | 1 | Interrupt request |
| irq_code | input | 8 | Event code of the interrupt |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 32 | Status word write data |
| accept_o | output | 1 | Single-cycle acceptance pulse |
| vec_o | output | 2 | Vector class of the accepted event |
| evt_code_o | output | 8 | Event code of the accepted event |
| flush_o | output | 1 | Committing instruction is cancelled |
| spc_o | output | 32 | Saved return address |
| ssr_o | output | 32 | Saved status word |
| sr_o | output | 32 | Live status word |

## Verification
The hardest case to reach is a complete-type exception on a taken delayed branch, because it must be held across commits and then come out at the slot commit with the target address. The stimulus table commits an unconditional branch that carries an exception and a competing interrupt. It then commits the slot and expects the held event. A second sequence places an idle cycle (no commit, interrupt raised) between a taken conditional branch and its slot, to show that the slot context survives stalls. Because every acceptance sets the block bit, status writes are interleaved so that each later case starts with the bit clear.

// File: rtl/exc_pkg.sv
package exc_pkg;

    parameter int unsigned XLEN       = 32;
    parameter int unsigned CODE_W     = 8;
    parameter int unsigned INSN_BYTES = 2;
    parameter int unsigned BL_BIT     = 28;

    localparam logic [XLEN-1:0]   SR_RESET     = XLEN'(1) << BL_BIT;
    localparam logic [CODE_W-1:0] EVT_RESET    = CODE_W'(8'h00);
    localparam logic [CODE_W-1:0] EVT_ESCALATE = CODE_W'(8'h01);

    typedef enum logic [1:0] {
        VEC_NONE    = 2'd0,
        VEC_RESET   = 2'd1,
        VEC_GENERAL = 2'd2,
        VEC_INTR    = 2'd3
    } vec_e;

    typedef enum logic [1:0] {
        BR_NONE   = 2'd0,
        BR_UNCOND = 2'd1,
        BR_COND   = 2'd2,
        BR_RSVD   = 2'd3
    } br_e;

    // Context left behind by the previous valid commit.
    typedef struct packed {
        logic            valid;   // previous commit was a taken delayed branch
        logic [XLEN-1:0] bpc;     // its address
        logic [XLEN-1:0] tgt;     // its target
    } slot_ctx_t;

    typedef struct packed {
        logic              acc;
        vec_e              vec;
        logic [CODE_W-1:0] code;
        logic              flush;
        logic              save;   // update saved PC / saved status
        logic [XLEN-1:0]   ret;
        logic              defer;  // hold a complete-type event until the slot
    } decision_t;

    function automatic logic br_is_taken(input br_e kind, input logic cond);
        return (kind == BR_UNCOND) || ((kind == BR_COND) && cond);
    endfunction

endpackage

// File: rtl/exc_slot_tracker.sv
module exc_slot_tracker
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_valid,
    input  logic              cur_taken,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_target,
    input  logic              any_accept,
    input  logic              defer_set,
    input  logic [CODE_W-1:0] defer_code_in,
    output slot_ctx_t         slot,
    output logic              defer_v,
    output logic [CODE_W-1:0] defer_code
);

    always_ff @(posedge clk) begin
        if (rst || any_accept) begin
            slot       <= '0;
            defer_v    <= 1'b0;
            defer_code <= '0;
        end else if (commit_valid) begin
            slot.valid <= cur_taken;
            slot.bpc   <= cur_pc;
            slot.tgt   <= cur_target;
            defer_v    <= defer_set;
            defer_code <= defer_code_in;
        end
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic              rst_req,
    input  logic              commit_valid,
    input  logic              cur_taken,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              gexc_req,
    input  logic              gexc_reexec,
    input  logic [CODE_W-1:0] gexc_code,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              bl,
    input  slot_ctx_t         slot,
    input  logic              defer_v,
    input  logic [CODE_W-1:0] defer_code,
    output decision_t         dec
);

    logic            in_slot;
    logic            gen_pend;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] resume_pc;

    assign in_slot   = commit_valid && slot.valid;
    assign gen_pend  = commit_valid && (gexc_req || defer_v);
    assign seq_pc    = cur_pc + XLEN'(INSN_BYTES);
    assign resume_pc = in_slot ? slot.tgt : seq_pc;

    always_comb begin
        dec     = '0;
        dec.vec = VEC_NONE;
        if (rst_req) begin
            dec.acc   = 1'b1;
            dec.vec   = VEC_RESET;
            dec.code  = EVT_RESET;
            dec.flush = 1'b1;
        end else if (gen_pend && bl) begin
            dec.acc   = 1'b1;
            dec.vec   = VEC_RESET;
            dec.code  = EVT_ESCALATE;
            dec.flush = 1'b1;
        end else if (commit_valid && defer_v) begin
            dec.acc  = 1'b1;
            dec.vec  = VEC_GENERAL;
            dec.code = defer_code;
            dec.save = 1'b1;
            dec.ret  = resume_pc;
        end else if (commit_valid && gexc_req && gexc_reexec) begin
            dec.acc   = 1'b1;
            dec.vec   = VEC_GENERAL;
            dec.code  = gexc_code;
            dec.flush = 1'b1;
            dec.save  = 1'b1;
            dec.ret   = in_slot ? slot.bpc : cur_pc;
        end else if (commit_valid && gexc_req && cur_taken) begin
            dec.defer = 1'b1;
        end else if (commit_valid && gexc_req) begin
            dec.acc  = 1'b1;
            dec.vec  = VEC_GENERAL;
            dec.code = gexc_code;
            dec.save = 1'b1;
            dec.ret  = resume_pc;
        end else if (commit_valid && irq_req && !bl && !cur_taken) begin
            dec.acc  = 1'b1;
            dec.vec  = VEC_INTR;
            dec.code = irq_code;
            dec.save = 1'b1;
            dec.ret  = resume_pc;
        end
    end

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  decision_t       dec,
    input  logic            sr_we,
    input  logic [XLEN-1:0] sr_wdata,
    output logic [XLEN-1:0] sr,
    output logic [XLEN-1:0] ssr,
    output logic [XLEN-1:0] spc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= SR_RESET;
            ssr <= '0;
            spc <= '0;
        end else if (dec.acc && dec.save) begin
            spc <= dec.ret;
            ssr <= sr;
            sr  <= sr | SR_RESET;
        end else if (dec.acc) begin
            sr <= SR_RESET;
        end else if (sr_we) begin
            sr <= sr_wdata;
        end
    end

endmodule

// File: rtl/exc_accept_unit.sv
module exc_accept_unit
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req,
    input  logic              commit_valid,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_br_kind,
    input  logic              cur_br_taken,
    input  logic [XLEN-1:0]   cur_br_target,
    input  logic              gexc_req,
    input  logic              gexc_reexec,
    input  logic [CODE_W-1:0] gexc_code,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              sr_we,
    input  logic [XLEN-1:0]   sr_wdata,
    output logic              accept_o,
    output logic [1:0]        vec_o,
    output logic [CODE_W-1:0] evt_code_o,
    output logic              flush_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   sr_o
);

    logic              cur_taken;
    slot_ctx_t         slot;
    logic              defer_v;
    logic [CODE_W-1:0] defer_code;
    decision_t         dec;

    assign cur_taken = commit_valid && br_is_taken(br_e'(cur_br_kind), cur_br_taken);

    exc_slot_tracker u_track (
        .clk           (clk),
        .rst           (rst),
        .commit_valid  (commit_valid),
        .cur_taken     (cur_taken),
        .cur_pc        (cur_pc),
        .cur_target    (cur_br_target),
        .any_accept    (dec.acc),
        .defer_set     (dec.defer),
        .defer_code_in (gexc_code),
        .slot          (slot),
        .defer_v       (defer_v),
        .defer_code    (defer_code)
    );

    exc_arbiter u_arb (
        .rst_req      (rst_req),
        .commit_valid (commit_valid),
        .cur_taken    (cur_taken),
        .cur_pc       (cur_pc),
        .gexc_req     (gexc_req),
        .gexc_reexec  (gexc_reexec),
        .gexc_code    (gexc_code),
        .irq_req      (irq_req),
        .irq_code     (irq_code),
        .bl           (sr_o[BL_BIT]),
        .slot         (slot),
        .defer_v      (defer_v),
        .defer_code   (defer_code),
        .dec          (dec)
    );

    exc_status_regs u_stat (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .sr_we    (sr_we),
        .sr_wdata (sr_wdata),
        .sr       (sr_o),
        .ssr      (ssr_o),
        .spc      (spc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_o   <= 1'b0;
            vec_o      <= VEC_NONE;
            evt_code_o <= '0;
            flush_o    <= 1'b0;
        end else begin
            accept_o   <= dec.acc;
            vec_o      <= dec.vec;
            evt_code_o <= dec.code;
            flush_o    <= dec.flush;
        end
    end

endmodule

// File: rtl/exc_accept_chk.sv
module exc_accept_chk
    import exc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rst_req,
    input logic              commit_valid,
    input logic              gexc_req,
    input logic              accept_o,
    input logic [1:0]        vec_o,
    input logic [CODE_W-1:0] evt_code_o,
    input logic [XLEN-1:0]   spc_o,
    input logic [XLEN-1:0]   ssr_o,
    input logic [XLEN-1:0]   sr_o
);

    p_reset_first_r1: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (accept_o && vec_o == VEC_RESET && evt_code_o == EVT_RESET));

    p_gen_over_irq_r2: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && gexc_req) |=> (vec_o != VEC_INTR));

    p_irq_held_bl_r2: assert property (@(posedge clk) disable iff (rst)
        sr_o[BL_BIT] |=> (vec_o != VEC_INTR));

    p_block_set_r8: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> sr_o[BL_BIT]);

    p_ssr_snap_r8: assert property (@(posedge clk) disable iff (rst)
        (accept_o && vec_o != VEC_RESET) |-> (ssr_o == $past(sr_o)));

    p_vec_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        accept_o == (vec_o != VEC_NONE));

    p_reset_keeps_saved_r11: assert property (@(posedge clk) disable iff (rst)
        (accept_o && vec_o == VEC_RESET) |-> ($stable(spc_o) && $stable(ssr_o)));

endmodule

bind exc_accept_unit exc_accept_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rst_req      (rst_req),
    .commit_valid (commit_valid),
    .gexc_req     (gexc_req),
    .accept_o     (accept_o),
    .vec_o        (vec_o),
    .evt_code_o   (evt_code_o),
    .spc_o        (spc_o),
    .ssr_o        (ssr_o),
    .sr_o         (sr_o)
);

// File: tb/sim_exc_accept_unit.sv
module sim_exc_accept_unit;

    localparam logic [31:0] BLV  = 32'h1000_0000;
    localparam logic [7:0]  IRQC = 8'h55;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_req = 0, commit_valid = 0, cur_br_taken = 0;
    logic [31:0] cur_pc = 0, cur_br_target;
    logic [1:0]  cur_br_kind = 0;
    logic        gexc_req = 0, gexc_reexec = 0, irq_req = 0, sr_we = 0;
    logic [7:0]  gexc_code = 0;
    logic [31:0] sr_wdata = 0;
    logic        accept_o, flush_o;
    logic [1:0]  vec_o;
    logic [7:0]  evt_code_o;
    logic [31:0] spc_o, ssr_o, sr_o;

    int ncmp = 0;
    int nbad = 0;

    assign cur_br_target = cur_pc + 32'h40;

    always #5 clk = ~clk;

    exc_accept_unit u0 (
        .clk(clk), .rst(rst), .rst_req(rst_req), .commit_valid(commit_valid),
        .cur_pc(cur_pc), .cur_br_kind(cur_br_kind), .cur_br_taken(cur_br_taken),
        .cur_br_target(cur_br_target), .gexc_req(gexc_req), .gexc_reexec(gexc_reexec),
        .gexc_code(gexc_code), .irq_req(irq_req), .irq_code(IRQC), .sr_we(sr_we),
        .sr_wdata(sr_wdata), .accept_o(accept_o), .vec_o(vec_o), .evt_code_o(evt_code_o),
        .flush_o(flush_o), .spc_o(spc_o), .ssr_o(ssr_o), .sr_o(sr_o)
    );

    // Row: rid, rst_req, commit, kind, taken, gexc, reexec, gcode, irq, sr_we(wdata 0), pc
    //      | exp accept, vec, code, flush, spc
    function automatic logic [64:0] mk(
        input logic [3:0] rid, input logic rq, input logic cv, input logic [1:0] kd,
        input logic tk, input logic gr, input logic rx, input logic [7:0] gc,
        input logic iq, input logic we, input logic [15:0] pc,
        input logic ea, input logic [1:0] ev, input logic [7:0] ec,
        input logic ef, input logic [15:0] es);
        return {rid, rq, cv, kd, tk, gr, rx, gc, iq, we, pc, ea, ev, ec, ef, es};
    endfunction

    localparam int NV = 28;
    localparam logic [64:0] TBL [NV] = '{
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000), // R12 clear block bit
        mk( 2, 0,1,0,0,0,0,8'h00,1,0,16'h0100, 1,3,8'h55,0,16'h0102), // R2 interrupt taken
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000),
        mk( 3, 0,1,0,0,1,1,8'h11,0,0,16'h0200, 1,2,8'h11,1,16'h0200), // R3 re-execute
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000),
        mk( 4, 0,1,0,0,1,0,8'h22,1,0,16'h0300, 1,2,8'h22,0,16'h0302), // R4 complete, wins over irq (R1)
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000),
        mk( 5, 0,1,1,0,0,0,8'h00,0,0,16'h0400, 0,0,8'h00,0,16'h0000), // R5 uncond branch
        mk( 5, 0,1,0,0,1,1,8'h33,0,0,16'h0402, 1,2,8'h33,1,16'h0400), // R5 re-exec in slot
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000),
        mk( 6, 0,1,2,1,0,0,8'h00,0,0,16'h0500, 0,0,8'h00,0,16'h0000), // R6 cond taken
        mk( 6, 0,1,0,0,0,0,8'h00,1,0,16'h0502, 1,3,8'h55,0,16'h0540), // R6 irq in slot
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000),
        mk( 7, 0,1,2,0,0,0,8'h00,0,0,16'h0600, 0,0,8'h00,0,16'h0000), // R7 cond not taken
        mk( 7, 0,1,0,0,1,1,8'h44,0,0,16'h0602, 1,2,8'h44,1,16'h0602), // R7 normal re-exec
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000),
        mk( 6, 0,1,1,0,1,0,8'h66,1,0,16'h0700, 0,0,8'h00,0,16'h0000), // R6 held on branch, irq blocked
        mk( 6, 0,1,0,0,0,0,8'h00,0,0,16'h0702, 1,2,8'h66,0,16'h0740), // R6 held event at slot
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000),
        mk( 6, 0,1,2,1,0,0,8'h00,0,0,16'h0800, 0,0,8'h00,0,16'h0000),
        mk( 2, 0,0,0,0,0,0,8'h00,1,0,16'h0000, 0,0,8'h00,0,16'h0000), // R2 no commit, irq waits
        mk( 6, 0,1,0,0,1,0,8'h77,0,0,16'h0802, 1,2,8'h77,0,16'h0840), // R6 complete in slot
        mk( 2, 0,1,0,0,0,0,8'h00,1,0,16'h0900, 0,0,8'h00,0,16'h0000), // R2 block bit set
        mk( 9, 0,1,0,0,1,1,8'h88,0,0,16'h0902, 1,1,8'h01,1,16'h0000), // R9 escalation
        mk( 1, 1,0,0,0,0,0,8'h00,0,0,16'h0000, 1,1,8'h00,1,16'h0000), // R1 reset
        mk(11, 1,0,0,0,0,0,8'h00,0,1,16'h0000, 1,1,8'h00,1,16'h0000), // R11 reset beats write
        mk(12, 0,0,0,0,0,0,8'h00,0,1,16'h0000, 0,0,8'h00,0,16'h0000),
        mk( 1, 1,1,0,0,1,0,8'h99,1,0,16'h0A00, 1,1,8'h00,1,16'h0000)  // R1 reset over all
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rst_req = 0; commit_valid = 0; cur_br_kind = 0; cur_br_taken = 0;
        gexc_req = 0; gexc_reexec = 0; gexc_code = 0; irq_req = 0;
        sr_we = 0; sr_wdata = 0; cur_pc = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // Reset state (R11)
        chk("R11 reset accept", {31'b0, accept_o}, 32'd0);
        chk("R11 reset vec", {30'b0, vec_o}, 32'd0);
        chk("R11 reset sr", sr_o, BLV);
        chk("R11 reset spc", spc_o, 32'd0);
        chk("R11 reset ssr", ssr_o, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [64:0] r;
            string       t;
            r = TBL[i];
            rst_req      = r[60];
            commit_valid = r[59];
            cur_br_kind  = r[58:57];
            cur_br_taken = r[56];
            gexc_req     = r[55];
            gexc_reexec  = r[54];
            gexc_code    = r[53:46];
            irq_req      = r[45];
            sr_we        = r[44];
            sr_wdata     = 32'd0;
            cur_pc       = {16'h0, r[43:28]};
            step();
            t = $sformatf("R%0d row%0d", r[64:61], i);
            chk({t, " accept"}, {31'b0, accept_o}, {31'b0, r[27]});
            chk({t, " vec"}, {30'b0, vec_o}, {30'b0, r[26:25]});
            if (r[27]) begin
                chk({t, " code"}, {24'b0, evt_code_o}, {24'b0, r[24:17]});
                chk({t, " flush"}, {31'b0, flush_o}, {31'b0, r[16]});
            end
            if (r[27] && r[26]) chk({t, " spc"}, spc_o, {16'h0, r[15:0]});
        end

        // R12: status write with no event
        idle_inputs();
        sr_we = 1; sr_wdata = 32'h0000_00A5;
        step();
        chk("R12 sr write", sr_o, 32'h0000_00A5);

        // R8: snapshot and block bit on an interrupt
        idle_inputs();
        commit_valid = 1; cur_pc = 32'h0B00; irq_req = 1;
        step();
        chk("R8 ssr", ssr_o, 32'h0000_00A5);
        chk("R8 sr", sr_o, 32'h1000_00A5);
        chk("R8 spc", spc_o, 32'h0000_0B02);

        // R10: pulse lasts one cycle
        idle_inputs();
        step();
        chk("R10 pulse low", {31'b0, accept_o}, 32'd0);

        // R9: escalation keeps saved registers
        idle_inputs();
        commit_valid = 1; cur_pc = 32'h0C00; gexc_req = 1; gexc_reexec = 1; gexc_code = 8'h12;
        step();
        chk("R9 vec", {30'b0, vec_o}, 32'd1);
        chk("R9 code", {24'b0, evt_code_o}, 32'h01);
        chk("R9 spc", spc_o, 32'h0000_0B02);
        chk("R9 ssr", ssr_o, 32'h0000_00A5);

        // R11: reset event keeps saved registers, status to reset value
        idle_inputs();
        rst_req = 1;
        step();
        chk("R11 spc kept", spc_o, 32'h0000_0B02);
        chk("R11 ssr kept", ssr_o, 32'h0000_00A5);
        chk("R11 sr value", sr_o, BLV);

        idle_inputs();
        step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

endmodule